// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This peripheral supervises system software with a 64-bit up-counter and a 64-bit period, each visible as a low and a high 32-bit word on a simple register bus. While the watchdog is still idle, software sets up the counting mode, the counter and the period. It then arms the timer with a two-word key handshake carrying the enable bit. From that point the configuration is frozen. Software must repeat the same two-word handshake often enough to restart the count. If the counter reaches the period, or any write to the watchdog control word carries an unexpected key, the block pulses a reset request for one cycle and raises a sticky timeout flag.

The control state machine has five states. WD_IDLE is the reset state and the only one in which configuration writes take effect. The arm transition (key 0xA5C6 with enable set, in WD_IDLE) leads to WD_PREACT. The go transition (key 0xDA7E, in WD_PREACT) leads to WD_ACTIVE. The service-open transition (key 0xA5C6, in WD_ACTIVE) leads to WD_SERVICE. The service-close transition (key 0xDA7E, in WD_SERVICE) clears the counter and returns to WD_ACTIVE. The fire transition happens from WD_PREACT, WD_ACTIVE or WD_SERVICE on a wrong key or a timeout, and leads to the terminal WD_FIRED. Only the system reset leaves WD_FIRED.

The byte offsets are fixed: counter low 0x10, counter high 0x14, period low 0x18, period high 0x1C, timer mode 0x20, global mode 0x24, watchdog control 0x28. All other offsets read as zero.

Top module: `wdog_top`

## Requirements
- R1: After reset every register reads zero, the state is WD_IDLE and the reset request output is low.
- R2: In WD_IDLE, writes to the counter, period, timer mode and global mode words take effect. A read returns the value on `bus_rdata` one cycle after the read strobe. Only bits 7:6 of the timer mode word and bits 3:0 of the global mode word are kept.
- R3: A write to the control word (0x28) with key field bits 31:16 = 0xA5C6 and enable bit 14 = 1 arms the watchdog, and bit 14 then reads 1. The same key with bit 14 = 0 leaves the block idle, with configuration still writable. In WD_IDLE a wrong key has no effect and raises no reset.
- R4: From WD_PREACT onward, writes to the counter, period, timer mode and global mode words are ignored.
- R5: The counter advances by one per cycle only in WD_ACTIVE or WD_SERVICE. It also needs timer mode bits 7:6 = 2, global mode bits 3:2 = 2 and both release bits 1:0 set. In WD_PREACT, or with the release bits clear, it holds.
- R6: When a running counter equals the period, the reset request pulses high for exactly one cycle. With period P, the pulse appears P+1 clock edges after the go write. The timeout flag, bit 15 of the control word, then reads 1.
- R7: The service handshake (0xA5C6, then 0xDA7E) clears the counter, so regular servicing prevents any timeout.
- R8: In WD_PREACT, WD_ACTIVE or WD_SERVICE, a control write whose key is not the expected one pulses the reset request on the next edge and sets the flag.
- R9: After firing, the flag and the enable bit stay set, no further reset pulse occurs and all writes are ignored until the system reset.
- R10: With a period of zero, the timeout fires on the first counting edge after the go write.
- R11: The count carries from the low word into the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| wd_reset_req | output | 1 | One-cycle reset request pulse |

## Verification
The assertions assume that the bus strobes are never both high in one cycle and that addresses are exact word offsets. The count-step property also assumes the period is never reached within a window that a service write cuts short. The bench drives one access at a time from tasks, always with aligned offsets. It applies a system reset before each scenario, so every check starts from WD_IDLE. Periods are chosen so that each expected timeout falls at a cycle the bench can predict from the go write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [2:0] {
        WD_IDLE    = 3'd0,
        WD_PREACT  = 3'd1,
        WD_ACTIVE  = 3'd2,
        WD_SERVICE = 3'd3,
        WD_FIRED   = 3'd4
    } wd_state_e;

    localparam logic [7:0] OFS_CNT_LO = 8'h10;
    localparam logic [7:0] OFS_CNT_HI = 8'h14;
    localparam logic [7:0] OFS_PRD_LO = 8'h18;
    localparam logic [7:0] OFS_PRD_HI = 8'h1C;
    localparam logic [7:0] OFS_TMODE  = 8'h20;
    localparam logic [7:0] OFS_GMODE  = 8'h24;
    localparam logic [7:0] OFS_WDCTL  = 8'h28;

    localparam int KEY_W    = 16;
    localparam int KEY_LSB  = 16;
    localparam int EN_BIT   = 14;
    localparam int FLAG_BIT = 15;
    localparam int TMODE_LSB = 6;

    localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hA5C6;
    localparam logic [KEY_W-1:0] KEY_CLOSE = 16'hDA7E;

    localparam logic [1:0] TMODE_CONT = 2'b10;
    localparam logic [1:0] GMODE_WD64 = 2'b10;

endpackage

// File: rtl/wdog_keyfsm.sv
module wdog_keyfsm
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [KEY_W-1:0] ctl_key,
    input  logic             ctl_en,
    input  logic             hit,
    output wd_state_e        st,
    output logic             counting,
    output logic             cnt_clr,
    output logic             flag,
    output logic             en,
    output logic             req
);

    wd_state_e nxt;
    logic      fire;
    logic      arm_go;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= WD_IDLE;
            flag <= 1'b0;
            en   <= 1'b0;
            req  <= 1'b0;
        end else begin
            st  <= nxt;
            req <= fire;
            if (fire)   flag <= 1'b1;
            if (arm_go) en   <= 1'b1;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt    = st;
        fire   = 1'b0;
        cnt_clr = 1'b0;
        arm_go = 1'b0;
        unique case (st)
            WD_IDLE: begin
                if (ctl_wr && ctl_en && ctl_key == KEY_OPEN) begin
                    nxt    = WD_PREACT;
                    arm_go = 1'b1;
                end
            end
            WD_PREACT: begin
                if (ctl_wr) begin
                    if (ctl_key == KEY_CLOSE) nxt = WD_ACTIVE;
                    else                      fire = 1'b1;
                end
            end
            WD_ACTIVE: begin
                if (hit) fire = 1'b1;
                else if (ctl_wr) begin
                    if (ctl_key == KEY_OPEN) nxt = WD_SERVICE;
                    else                     fire = 1'b1;
                end
            end
            WD_SERVICE: begin
                if (hit) fire = 1'b1;
                else if (ctl_wr) begin
                    if (ctl_key == KEY_CLOSE) begin
                        nxt     = WD_ACTIVE;
                        cnt_clr = 1'b1;
                    end else begin
                        fire = 1'b1;
                    end
                end
            end
            WD_FIRED: nxt = WD_FIRED;
            default:  nxt = WD_IDLE;
        endcase
        if (fire) nxt = WD_FIRED;
    end

    assign counting = (st == WD_ACTIVE) || (st == WD_SERVICE);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          wr_half,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                clr,
    input  logic                run,
    input  logic [2*DATA_W-1:0] prd,
    output logic [2*DATA_W-1:0] cnt,
    output logic                hit
);

    localparam int CNT_W = 2 * DATA_W;
    localparam int NHALF = 2;

    logic [CNT_W-1:0] cnt_nxt;

    assign hit = run && (cnt == prd);

    always_comb begin
        cnt_nxt = cnt;
        if (clr) begin
            cnt_nxt = '0;
        end else begin
            for (int h = 0; h < NHALF; h++) begin
                if (wr_half[h]) cnt_nxt[h*DATA_W +: DATA_W] = wdata;
            end
            if (run && !hit) cnt_nxt = cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                locked,
    input  logic [2*DATA_W-1:0] cnt,
    input  logic                flag,
    input  logic                en,
    output logic [2*DATA_W-1:0] prd,
    output logic                cfg_ok,
    output logic [1:0]          cnt_wr,
    output logic                ctl_wr,
    output logic [DATA_W-1:0]   bus_rdata
);

    logic       sel_clo, sel_chi, sel_plo, sel_phi, sel_tm, sel_gm, sel_ctl;
    logic [1:0] tmode;
    logic [3:0] gmode;
    logic       cfg_we;
    logic [DATA_W-1:0] rval;

    assign sel_clo = (bus_addr == ADDR_W'(OFS_CNT_LO));
    assign sel_chi = (bus_addr == ADDR_W'(OFS_CNT_HI));
    assign sel_plo = (bus_addr == ADDR_W'(OFS_PRD_LO));
    assign sel_phi = (bus_addr == ADDR_W'(OFS_PRD_HI));
    assign sel_tm  = (bus_addr == ADDR_W'(OFS_TMODE));
    assign sel_gm  = (bus_addr == ADDR_W'(OFS_GMODE));
    assign sel_ctl = (bus_addr == ADDR_W'(OFS_WDCTL));

    assign cfg_we = bus_wr && !locked;
    assign cnt_wr = {cfg_we && sel_chi, cfg_we && sel_clo};
    assign ctl_wr = bus_wr && sel_ctl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd   <= '0;
            tmode <= '0;
            gmode <= '0;
        end else if (cfg_we) begin
            if (sel_plo) prd[DATA_W-1:0]        <= bus_wdata;
            if (sel_phi) prd[2*DATA_W-1:DATA_W] <= bus_wdata;
            if (sel_tm)  tmode <= bus_wdata[TMODE_LSB +: 2];
            if (sel_gm)  gmode <= bus_wdata[3:0];
        end
    end

    assign cfg_ok = (tmode == TMODE_CONT) && (gmode[3:2] == GMODE_WD64)
                    && (gmode[1:0] == 2'b11);

    always_comb begin
        rval = '0;
        if (sel_clo) rval = cnt[DATA_W-1:0];
        if (sel_chi) rval = cnt[2*DATA_W-1:DATA_W];
        if (sel_plo) rval = prd[DATA_W-1:0];
        if (sel_phi) rval = prd[2*DATA_W-1:DATA_W];
        if (sel_tm)  rval[TMODE_LSB +: 2] = tmode;
        if (sel_gm)  rval[3:0] = gmode;
        if (sel_ctl) begin
            rval[FLAG_BIT] = flag;
            rval[EN_BIT]   = en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rval;
    end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_reset_req
);

    localparam int CNT_W = 2 * DATA_W;

    wd_state_e        st;
    logic             counting, cnt_clr, flag, en, hit, cfg_ok, ctl_wr;
    logic             cnt_run;
    logic [1:0]       cnt_wr;
    logic [CNT_W-1:0] cnt, prd;

    assign cnt_run = counting && cfg_ok;

    wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .locked    (st != WD_IDLE),
        .cnt       (cnt),
        .flag      (flag),
        .en        (en),
        .prd       (prd),
        .cfg_ok    (cfg_ok),
        .cnt_wr    (cnt_wr),
        .ctl_wr    (ctl_wr),
        .bus_rdata (bus_rdata)
    );

    wdog_keyfsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_key  (bus_wdata[KEY_LSB +: KEY_W]),
        .ctl_en   (bus_wdata[EN_BIT]),
        .hit      (hit),
        .st       (st),
        .counting (counting),
        .cnt_clr  (cnt_clr),
        .flag     (flag),
        .en       (en),
        .req      (wd_reset_req)
    );

    wdog_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_half (cnt_wr),
        .wdata   (bus_wdata),
        .clr     (cnt_clr),
        .run     (cnt_run),
        .prd     (prd),
        .cnt     (cnt),
        .hit     (hit)
    );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input wd_state_e        st,
    input logic             flag,
    input logic             en,
    input logic             run,
    input logic             clr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] prd
);

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);                                             // R6
    AST_REQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> flag);                                             // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);                                            // R9
    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);                                                // R9
    AST_FIRED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_FIRED && $past(st) == WD_FIRED) |-> !req);       // R9
    AST_PRD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st != WD_IDLE) |=> $stable(prd));                         // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && cnt != prd) |=> cnt == $past(cnt) + CNT_W'(1)); // R5
    AST_HOLD_PREACT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_PREACT && $past(st) == WD_PREACT) |-> $stable(cnt)); // R5

endmodule

bind wdog_top wdog_checker #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (wd_reset_req),
    .st    (st),
    .flag  (flag),
    .en    (en),
    .run   (cnt_run),
    .clr   (cnt_clr),
    .cnt   (cnt),
    .prd   (prd)
);

// File: tb/wdog_top_bench.sv
`timescale 1ns/1ps
module wdog_top_bench;

    localparam logic [5:0] A_CLO = 6'h10, A_CHI = 6'h14, A_PLO = 6'h18,
                           A_PHI = 6'h1C, A_TM = 6'h20, A_GM = 6'h24,
                           A_CTL = 6'h28;
    localparam logic [31:0] K_OPEN_EN  = 32'hA5C6_4000;
    localparam logic [31:0] K_CLOSE_EN = 32'hDA7E_4000;
    localparam logic [31:0] K_OPEN     = 32'hA5C6_0000;
    localparam logic [31:0] K_CLOSE    = 32'hDA7E_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_reset_req;

    int total = 0;
    int bad = 0;
    int pulses = 0;

    always #2 clk = ~clk;

    wdog_top u_wdog_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .wd_reset_req (wd_reset_req)
    );

    always @(negedge clk) if (rst_n && wd_reset_req) pulses++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pulses = 0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic setup(input logic [31:0] plo, input logic [31:0] phi);
        wr(A_TM, 32'h80);
        wr(A_GM, 32'hB);
        wr(A_PLO, plo);
        wr(A_PHI, phi);
    endtask

    task automatic arm();
        wr(A_CTL, K_OPEN_EN);
        wr(A_CTL, K_CLOSE_EN);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R1 req low", 64'(wd_reset_req), 64'd0);
        rd(A_CLO, d); chk("R1 cnt lo", 64'(d), 64'd0);
        rd(A_PHI, d); chk("R1 prd hi", 64'(d), 64'd0);
        rd(A_GM, d);  chk("R1 gmode", 64'(d), 64'd0);
        rd(A_CTL, d); chk("R1 ctl", 64'(d), 64'd0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        do_reset();
        wr(A_PLO, 32'h1234_5678); wr(A_CHI, 32'hCAFE_0001);
        wr(A_TM, 32'hFFFF_FFFF);  wr(A_GM, 32'hFFFF_FFFB);
        rd(A_PLO, d); chk("R2 prd lo", 64'(d), 64'h1234_5678);
        rd(A_CHI, d); chk("R2 cnt hi", 64'(d), 64'hCAFE_0001);
        rd(A_TM, d);  chk("R2 tmode field", 64'(d), 64'hC0);
        rd(A_GM, d);  chk("R2 gmode field", 64'(d), 64'hB);
    endtask

    task automatic t_arm_lock();
        logic [31:0] d;
        do_reset();
        setup(32'd5, 32'd1);
        wr(A_CTL, K_OPEN);
        wr(A_CTL, 32'h1111_4000);
        chk("R3 wrong key idle no req", 64'(pulses), 64'd0);
        wr(A_PLO, 32'd9);
        rd(A_PLO, d); chk("R3 still idle writable", 64'(d), 64'd9);
        rd(A_CTL, d); chk("R3 en clear", 64'(d), 64'd0);
        wr(A_CTL, K_OPEN_EN);
        rd(A_CTL, d); chk("R3 en set", 64'(d), 64'h4000);
        wr(A_PLO, 32'd77); wr(A_CLO, 32'd55); wr(A_TM, 32'd0); wr(A_GM, 32'd0);
        rd(A_PLO, d); chk("R4 prd locked", 64'(d), 64'd9);
        rd(A_CLO, d); chk("R4 cnt locked", 64'(d), 64'd0);
        rd(A_TM, d);  chk("R4 tmode locked", 64'(d), 64'h80);
        rd(A_GM, d);  chk("R4 gmode locked", 64'(d), 64'hB);
        wr(A_CTL, K_CLOSE_EN);
        repeat (3) @(negedge clk);
        chk("R3 armed no req", 64'(pulses), 64'd0);
    endtask

    task automatic t_count();
        logic [31:0] a, b;
        do_reset();
        setup(32'd0, 32'd1);
        wr(A_CTL, K_OPEN_EN);
        rd(A_CLO, a); rd(A_CLO, b);
        chk("R5 hold in preact", 64'(b - a), 64'd0);
        wr(A_CTL, K_CLOSE_EN);
        rd(A_CLO, a); rd(A_CLO, b);
        chk("R5 step one", 64'(b - a), 64'd1);
        do_reset();
        wr(A_TM, 32'h80); wr(A_GM, 32'h8); wr(A_PLO, 32'd3);
        arm();
        repeat (20) @(negedge clk);
        rd(A_CLO, a);
        chk("R5 halves held no count", 64'(a), 64'd0);
        chk("R5 no timeout when held", 64'(pulses), 64'd0);
    endtask

    task automatic t_timeout(input int p, input string req);
        logic [31:0] d;
        int n;
        do_reset();
        setup(32'(p), 32'd0);
        arm();
        n = 0;
        while (!wd_reset_req && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(req, 64'(n), 64'(p + 1));
        @(negedge clk);
        chk("R6 pulse width", 64'(wd_reset_req), 64'd0);
        rd(A_CTL, d); chk("R6 flag set", 64'(d), 64'hC000);
    endtask

    task automatic t_service();
        logic [31:0] d;
        do_reset();
        setup(32'd20, 32'd0);
        arm();
        for (int i = 0; i < 10; i++) begin
            repeat (10) @(negedge clk);
            wr(A_CTL, K_OPEN);
            wr(A_CTL, K_CLOSE);
            rd(A_CLO, d);
            if (i == 0) chk("R7 cnt cleared", 64'(d), 64'd0);
        end
        chk("R7 no timeout", 64'(pulses), 64'd0);
    endtask

    task automatic t_badkey();
        logic [31:0] d;
        do_reset();
        setup(32'd0, 32'd1);
        arm();
        wr(A_CTL, 32'h0000_4000);
        chk("R8 req active bad key", 64'(wd_reset_req), 64'd1);
        rd(A_CTL, d); chk("R8 flag", 64'(d), 64'hC000);
        do_reset();
        setup(32'd0, 32'd1);
        arm();
        wr(A_CTL, K_OPEN);
        wr(A_CTL, K_OPEN);
        chk("R8 req service bad key", 64'(wd_reset_req), 64'd1);
        do_reset();
        setup(32'd0, 32'd1);
        wr(A_CTL, K_OPEN_EN);
        wr(A_CTL, 32'h1234_4000);
        chk("R8 req preact bad key", 64'(wd_reset_req), 64'd1);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        do_reset();
        setup(32'd0, 32'd1);
        arm();
        wr(A_CTL, K_CLOSE);
        wr(A_CTL, 32'h0);
        arm();
        wr(A_PLO, 32'd42);
        repeat (50) @(negedge clk);
        chk("R9 single pulse", 64'(pulses), 64'd1);
        rd(A_CTL, d); chk("R9 flag en kept", 64'(d), 64'hC000);
        rd(A_PLO, d); chk("R9 writes ignored", 64'(d), 64'd0);
        do_reset();
        rd(A_CTL, d); chk("R9 reset clears", 64'(d), 64'd0);
    endtask

    task automatic t_carry();
        logic [31:0] d;
        do_reset();
        setup(32'd0, 32'd2);
        wr(A_CLO, 32'hFFFF_FFFD);
        arm();
        repeat (10) @(negedge clk);
        rd(A_CHI, d); chk("R11 carry to hi", 64'(d), 64'd1);
        chk("R11 no timeout", 64'(pulses), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_config();
        t_arm_lock();
        t_count();
        t_timeout(6, "R6 timeout cycle");
        t_timeout(0, "R10 zero period");
        t_service();
        t_badkey();
        t_sticky();
        t_carry();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule